// File: doc/BRIEF.md
# Debug Register File with Privilege and Detect Guard

This block holds the debug register set of a processor core: four breakpoint address registers, a status register and a control register. The execution pipeline presents one move-to or move-from request per cycle, with a 3-bit register index, write data, the current privilege level, the protected-mode and virtual-8086 flags, and whether the operand was in register form. The block decides in the same cycle whether the access is allowed. It then either performs the access or signals exactly one fault, and registers the result for the following cycle.

Faults are ranked in a fixed order. A memory-form operand is rejected as an undefined opcode. A privileged access from the wrong mode is a general-protection fault. When the general-detect bit is set in the control register, any access becomes a debug fault: the breakpoint-detect bit in the status register is set, general-detect is cleared, and the requested access is dropped. Status reads return a fixed pattern on the reserved bits. Index 4 reads alias the status register. A control-register write also pulses a clear of the breakpoint-armed state held elsewhere in the core.

Each accepted request loads one state of a small result machine, which drives the outputs for exactly one cycle:
- IDLE: nothing is driven. Entered when no request is present.
- READ: read data is driven with its valid flag.
- WRITE: a breakpoint or status write completed.
- WCTL: a control-register write completed, and the breakpoint clear is pulsed.
- GP, DB, UD: the matching fault pulse is driven.

Every state returns to IDLE on the next cycle unless a new request selects another state. These are the only transitions.

Top module: `dbg_regfile_guard`

## Requirements
- R1: A request with reg_form low raises fault_ud. This check outranks all others, and no register changes.
- R2: A register-form request with prot_mode high and either v86_mode high or cpl not 0 raises fault_gp. This check outranks the general-detect check, and no register changes.
- R3: If control bit 13 (general-detect) is set when an otherwise permitted access arrives, fault_db is raised, status bit 13 is set, and control bit 13 is cleared. The requested read or write is not performed.
- R4: A permitted read of index 4 or 6 returns (status AND 0x0000F00F) OR 0xFFFF0FF0.
- R5: Indices 0 to 3 write and read the four breakpoint address registers unchanged.
- R6: A write of index 6 stores all 32 bits into status. A write of index 7 stores all 32 bits into control and pulses bp_clear. A read of index 7 returns control.
- R7: A write of index 4 or 5, or a read of index 5, raises fault_ud and changes no register.
- R8: After reset the breakpoint registers read 0, control reads 0x00000400, and status reads 0xFFFF0FF0. All outputs are low during reset.
- R9: Results appear in the cycle after the request and last one cycle. At most one of rd_valid, fault_gp, fault_db and fault_ud is high. With no request, all outputs are low the next cycle.
- R10: With prot_mode low, accesses are allowed whatever cpl and v86_mode are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = move to debug register, 0 = move from |
| req_idx | input | 3 | Debug register index |
| req_wdata | input | 32 | Write data |
| cpl | input | 2 | Current privilege level |
| prot_mode | input | 1 | Protected mode active |
| v86_mode | input | 1 | Virtual-8086 mode active |
| reg_form | input | 1 | Operand is a register (not memory) |
| rd_data | output | 32 | Read result, zero when rd_valid is low |
| rd_valid | output | 1 | Read result valid |
| fault_gp | output | 1 | General-protection fault pulse |
| fault_db | output | 1 | Debug fault pulse |
| fault_ud | output | 1 | Undefined-opcode fault pulse |
| bp_clear | output | 1 | Breakpoint-armed state clear pulse |

## Verification
Every result is due exactly one clock after the edge that samples its request. A register update is visible to a request issued in the following cycle. The bench drives requests on the falling edge and advances a behavioural model on the rising edge, so the model and the block see the same inputs. It compares all outputs against the model on each falling edge, half a cycle after they settle. Directed sequences cover reset values, aliasing, fault ranking and the general-detect trap. A long mixed sequence then hits the ordering cases again in varied combinations.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_WCTL,
        ST_GP,
        ST_DB,
        ST_UD
    } dbg_state_e;

    localparam int unsigned DETECT_BIT = 13;   // control: general-detect
    localparam int unsigned HIT_BIT    = 13;   // status: detect hit
    localparam logic [2:0]  IDX_ALIAS  = 3'd4;
    localparam logic [2:0]  IDX_HOLE   = 3'd5;
    localparam logic [2:0]  IDX_STAT   = 3'd6;
    localparam logic [2:0]  IDX_CTRL   = 3'd7;

endpackage

// File: rtl/dbg_access_guard.sv
module dbg_access_guard
    import dbg_pkg::*;
#(
    parameter int unsigned NUM_BP = 4
) (
    input  logic       req_valid,
    input  logic       req_write,
    input  logic [2:0] req_idx,
    input  logic [1:0] cpl,
    input  logic       prot_mode,
    input  logic       v86_mode,
    input  logic       reg_form,
    input  logic       detect_armed,
    output dbg_state_e next_state
);

    logic is_bp;
    logic priv_bad;
    logic idx_bad;

    assign is_bp    = (32'(req_idx) < NUM_BP);
    assign priv_bad = prot_mode && (v86_mode || (cpl != 2'd0));
    assign idx_bad  = req_write ? (req_idx == IDX_ALIAS || req_idx == IDX_HOLE)
                                : (req_idx == IDX_HOLE);

    always_comb begin
        if (!req_valid)        next_state = ST_IDLE;
        else if (!reg_form)    next_state = ST_UD;
        else if (priv_bad)     next_state = ST_GP;
        else if (detect_armed) next_state = ST_DB;
        else if (idx_bad)      next_state = ST_UD;
        else if (!req_write)   next_state = ST_READ;
        else if (is_bp || req_idx == IDX_STAT) next_state = ST_WRITE;
        else                   next_state = ST_WCTL;
    end

endmodule

// File: rtl/dbg_reg_bank.sv
module dbg_reg_bank
    import dbg_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_BP    = 4,
    parameter logic [DATA_W-1:0] STAT_RST  = 32'hFFFF0FF0,
    parameter logic [DATA_W-1:0] CTRL_RST  = 32'h00000400,
    parameter logic [DATA_W-1:0] STAT_KEEP = 32'h0000F00F,
    parameter logic [DATA_W-1:0] STAT_ONES = 32'hFFFF0FF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              detect_hit,
    output logic [DATA_W-1:0] rd_data,
    output logic              detect_armed
);

    logic [DATA_W-1:0] bp_q [NUM_BP];
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] ctrl_q;

    for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
        always_ff @(posedge clk) begin
            if (!rst_n)
                bp_q[g] <= '0;
            else if (wr_en && 32'(idx) == g)
                bp_q[g] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= STAT_RST;
            ctrl_q <= CTRL_RST;
        end else if (detect_hit) begin
            stat_q[HIT_BIT]    <= 1'b1;
            ctrl_q[DETECT_BIT] <= 1'b0;
        end else if (wr_en) begin
            if (idx == IDX_STAT) stat_q <= wr_data;
            if (idx == IDX_CTRL) ctrl_q <= wr_data;
        end
    end

    assign detect_armed = ctrl_q[DETECT_BIT];

    always_comb begin
        rd_data = '0;
        if (32'(idx) < NUM_BP)
            rd_data = bp_q[idx[$clog2(NUM_BP)-1:0]];
        else if (idx == IDX_ALIAS || idx == IDX_STAT)
            rd_data = (stat_q & STAT_KEEP) | STAT_ONES;
        else if (idx == IDX_CTRL)
            rd_data = ctrl_q;
    end

endmodule

// File: rtl/dbg_regfile_guard.sv
module dbg_regfile_guard
    import dbg_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NUM_BP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [2:0]        req_idx,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        cpl,
    input  logic              prot_mode,
    input  logic              v86_mode,
    input  logic              reg_form,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              fault_gp,
    output logic              fault_db,
    output logic              fault_ud,
    output logic              bp_clear
);

    dbg_state_e        state_q;
    dbg_state_e        state_d;
    logic [DATA_W-1:0] bank_rd;
    logic [DATA_W-1:0] rdata_q;
    logic              armed;

    dbg_access_guard #(.NUM_BP(NUM_BP)) u_guard (
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_idx      (req_idx),
        .cpl          (cpl),
        .prot_mode    (prot_mode),
        .v86_mode     (v86_mode),
        .reg_form     (reg_form),
        .detect_armed (armed),
        .next_state   (state_d)
    );

    dbg_reg_bank #(.DATA_W(DATA_W), .NUM_BP(NUM_BP)) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (state_d == ST_WRITE || state_d == ST_WCTL),
        .idx          (req_idx),
        .wr_data      (req_wdata),
        .detect_hit   (state_d == ST_DB),
        .rd_data      (bank_rd),
        .detect_armed (armed)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= (state_d == ST_READ) ? bank_rd : '0;
        end
    end

    // Outputs
    always_comb begin
        rd_data  = '0;
        rd_valid = 1'b0;
        fault_gp = 1'b0;
        fault_db = 1'b0;
        fault_ud = 1'b0;
        bp_clear = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_READ:  begin rd_data = rdata_q; rd_valid = 1'b1; end
            ST_WRITE: ;
            ST_WCTL:  bp_clear = 1'b1;
            ST_GP:    fault_gp = 1'b1;
            ST_DB:    fault_db = 1'b1;
            ST_UD:    fault_ud = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/dbg_regfile_guard_chk.sv
module dbg_regfile_guard_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [2:0]  req_idx,
    input logic [1:0]  cpl,
    input logic        prot_mode,
    input logic        v86_mode,
    input logic        reg_form,
    input logic [31:0] rd_data,
    input logic        rd_valid,
    input logic        fault_gp,
    input logic        fault_db,
    input logic        fault_ud,
    input logic        bp_clear
);

    p_mem_form_ud_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !reg_form |=> fault_ud);

    p_priv_gp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && reg_form && prot_mode && (v86_mode || cpl != 2'd0) |=> fault_gp);

    p_db_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fault_db |-> !bp_clear && !rd_valid);

    p_stat_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && $past(req_idx == 3'd4 || req_idx == 3'd6)
        |-> (rd_data & 32'hFFFF0FF0) == 32'hFFFF0FF0);

    p_clear_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bp_clear |-> $past(req_valid && req_write && req_idx == 3'd7));

    p_one_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, fault_gp, fault_db, fault_ud}));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(rd_valid || fault_gp || fault_db || fault_ud || bp_clear));

    p_real_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && reg_form && !prot_mode |=> !fault_gp);

endmodule

bind dbg_regfile_guard dbg_regfile_guard_chk u_chk (.*);

// File: tb/dbg_regfile_guard_tb.sv
module dbg_regfile_guard_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_idx = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  cpl = '0;
    logic        prot_mode = 1'b0;
    logic        v86_mode = 1'b0;
    logic        reg_form = 1'b1;
    logic [31:0] rd_data;
    logic        rd_valid, fault_gp, fault_db, fault_ud, bp_clear;

    always #2.5 clk = ~clk;

    dbg_regfile_guard u_dut (.*);

    // Behavioural reference model
    logic [31:0] m_bp [4];
    logic [31:0] m_stat, m_ctrl;
    logic [31:0] e_data;
    logic        e_rv, e_gp, e_db, e_ud, e_bpc;
    string       e_tag = "R8";
    string       phase_tag = "";
    bit          started = 0;
    int          n_chk = 0, n_fail = 0;

    always @(posedge clk) begin
        string t;
        started <= 1;
        e_data <= 0; e_rv <= 0; e_gp <= 0; e_db <= 0; e_ud <= 0; e_bpc <= 0;
        t = "R9";
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_bp[i] <= 0;
            m_stat <= 32'hFFFF0FF0;
            m_ctrl <= 32'h00000400;
            t = "R8";
        end else if (req_valid) begin
            if (!reg_form) begin e_ud <= 1; t = "R1"; end
            else if (prot_mode && (v86_mode || cpl != 0)) begin e_gp <= 1; t = "R2"; end
            else if (m_ctrl[13]) begin
                e_db <= 1; m_stat[13] <= 1; m_ctrl[13] <= 0; t = "R3";
            end else if (req_write) begin
                if (req_idx < 4) begin m_bp[req_idx[1:0]] <= req_wdata; t = "R5"; end
                else if (req_idx == 6) begin m_stat <= req_wdata; t = "R6"; end
                else if (req_idx == 7) begin m_ctrl <= req_wdata; e_bpc <= 1; t = "R6"; end
                else begin e_ud <= 1; t = "R7"; end
            end else begin
                if (req_idx < 4) begin e_rv <= 1; e_data <= m_bp[req_idx[1:0]]; t = "R5"; end
                else if (req_idx == 4 || req_idx == 6) begin
                    e_rv <= 1; e_data <= (m_stat & 32'h0000F00F) | 32'hFFFF0FF0; t = "R4";
                end else if (req_idx == 7) begin e_rv <= 1; e_data <= m_ctrl; t = "R6"; end
                else begin e_ud <= 1; t = "R7"; end
            end
            if (reg_form && !prot_mode && (cpl != 0 || v86_mode) && t != "R3" && t != "R7")
                t = "R10";
        end
        e_tag <= (phase_tag != "") ? phase_tag : t;
    end

    always @(negedge clk) begin
        if (started) begin
            n_chk++;
            if ({rd_data, rd_valid, fault_gp, fault_db, fault_ud, bp_clear} !==
                {e_data, e_rv, e_gp, e_db, e_ud, e_bpc}) begin
                n_fail++;
                $display("FAIL %s: got data=%h rv=%b gp=%b db=%b ud=%b clr=%b, expected data=%h rv=%b gp=%b db=%b ud=%b clr=%b",
                         e_tag, rd_data, rd_valid, fault_gp, fault_db, fault_ud, bp_clear,
                         e_data, e_rv, e_gp, e_db, e_ud, e_bpc);
            end
        end
    end

    task automatic issue(input logic w, input logic [2:0] i, input logic [31:0] d,
                         input logic [1:0] pl, input logic pm, input logic v8, input logic rf);
        req_valid = 1; req_write = w; req_idx = i; req_wdata = d;
        cpl = pl; prot_mode = pm; v86_mode = v8; reg_form = rf;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic rd(input logic [2:0] i);
        issue(0, i, 0, 0, 1, 0, 1);
    endtask

    task automatic wr(input logic [2:0] i, input logic [31:0] d);
        issue(1, i, d, 0, 1, 0, 1);
    endtask

    bit done = 0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R8: reset values
        phase_tag = "R8";
        for (int i = 0; i < 8; i++) if (i != 5) rd(3'(i));
        phase_tag = "";
        // R5: breakpoint registers
        for (int i = 0; i < 4; i++) wr(3'(i), 32'hA5A50000 + 32'(i) * 32'h1111);
        for (int i = 0; i < 4; i++) rd(3'(i));
        // R6 / R4: status store and masked aliases
        wr(6, 32'h1234ABCD); rd(6); rd(4);
        wr(7, 32'h00FF0401); rd(7);
        // R7: holes
        wr(4, 32'hFFFFFFFF); wr(5, 32'hFFFFFFFF); rd(5); rd(6);
        // R1: memory form even with bad privilege
        issue(0, 0, 0, 3, 1, 1, 0);
        issue(1, 7, 32'h0, 0, 1, 0, 0);
        rd(7);
        // R2: privilege faults
        issue(1, 0, 32'hDEAD0000, 3, 1, 0, 1);
        issue(0, 1, 0, 0, 1, 1, 1);
        rd(0);
        // R10: real mode ignores cpl and v86
        issue(1, 2, 32'h0BADF00D, 3, 0, 1, 1);
        issue(0, 2, 0, 2, 0, 0, 1);
        // R3: general detect trap, with R2 priority first
        wr(6, 32'h0); wr(7, 32'h00002400);
        issue(0, 7, 0, 1, 1, 0, 1);      // GP wins, detect stays set
        wr(0, 32'h11111111);              // DB, write dropped
        rd(0); rd(6); rd(7);
        wr(7, 32'h00002000);
        rd(5);                            // DB before index hole
        rd(5);
        // idle gap
        repeat (3) @(negedge clk);
        // Mixed sequence
        for (int n = 0; n < 600; n++) begin
            if ($urandom % 4 == 0) @(negedge clk);
            else issue($urandom % 2 == 1, 3'($urandom % 8), $urandom,
                       ($urandom % 4 == 0) ? 2'($urandom) : 2'd0,
                       $urandom % 3 != 0, $urandom % 8 == 0, $urandom % 10 != 0);
        end
        repeat (2) @(negedge clk);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R9: watchdog expired, got hung run, expected completion");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule